// File: doc/BRIEF.md
# Input Automatic Level Controller

This block steers the 6-bit gain code of a microphone preamplifier from the peak levels of the signed samples that the ADC returns. Each sample that arrives with its strobe is rectified and compared against two thresholds. The first is a programmable target level. The second is a fixed clip guard at seven eighths of full scale. The gain moves in single-code steps of 0.75 dB. Code 0 is -12 dB, code 16 is 0 dB and code 63 is +35.25 dB. All delays are counted in samples, not in clock cycles.

While the sample peaks stay above target, the gain falls by one code at the attack rate. When a sample is clipping, the gain falls at the fastest attack rate whatever the attack field holds. When no peak has crossed the target for a hold delay, the gain climbs by one code at the decay rate. In limiter mode the gain never climbs past the value it held when the controller was enabled. In both modes the gain is kept inside a programmable minimum/maximum window. While the controller is disabled the gain is frozen, and only a host load can change it.

Top module: `level_ctrl`

## Requirements
- R1: After reset, gain_code and gain_rb both read RESET_GAIN (default 16, the 0 dB code).
- R2: A host load (host_we high for one cycle) sets the gain to host_gain one cycle later while run_en is low. While run_en is high the load is ignored.
- R3: While run_en is low, samples have no effect and the gain stays constant apart from host loads.
- R4: The magnitude of a sample is compared against the threshold (target+1)·2^(W-5). A magnitude strictly above the threshold is an attack sample. Every P attack samples lower the gain by one code, but never below gain_min. P = B·2^atk_code, where B is NORM_BASE in normal mode (limit_mode=0) and LIM_BASE in limiter mode (limit_mode=1).
- R5: A sample whose magnitude is strictly above 7·2^(W-4) is a clip sample. It counts as an attack sample with period B, whatever atk_code holds. The most negative input value counts as clipping.
- R6: A quiet sample is a sample that is not an attack sample. After an attack sample, the first H quiet samples only count the hold delay. H = 0 for hold code 0, and HOLD_BASE·2^(c-1) for hold codes c = 1..10. Hold codes above 10 act as 10.
- R7: Once the hold delay has run out, every DCY_BASE·2^dcy_code quiet samples raise the gain by one code, up to a ceiling.
- R8: In normal mode the ceiling is gain_max. In limiter mode the ceiling is the smaller of gain_max and the gain captured on the cycle run_en rose.
- R9: While the controller is running and the gain is outside [gain_min, gain_max], the gain moves to the violated limit on the next clock edge. If the gain is above gain_max it moves to gain_max, otherwise to gain_min.
- R10: gain_rb always equals gain_code.
- R11: A sample strobed at clock edge N changes the gain at edge N+1, two registers later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed ADC sample |
| run_en | input | 1 | Controller enable |
| limit_mode | input | 1 | 0 normal mode, 1 limiter mode |
| target_lvl | input | 4 | Target level field |
| atk_code | input | 4 | Attack rate code |
| dcy_code | input | 4 | Decay rate code |
| hold_code | input | 4 | Hold delay code |
| gain_min | input | 6 | Lowest gain code allowed |
| gain_max | input | 6 | Highest gain code allowed |
| host_we | input | 1 | Host gain load strobe |
| host_gain | input | 6 | Host gain load value |
| gain_code | output | 6 | Gain code to the preamp |
| gain_rb | output | 6 | Readable copy of the current gain |

## Verification
The bench builds the block with NORM_BASE=4, LIM_BASE=1, DCY_BASE=2 and HOLD_BASE=2. With these bases every attack and decay step, and the hold delay at the clamped code (1024 samples), fall within a few thousand cycles. The small bases also let the random phase cross the hold-to-decay boundary and the window limits many times. The limiter base of 1 makes single-sample attack steps visible. The normal base of 4 keeps the clip guard's override of a slow attack code measurable.

// File: rtl/lvlc_pkg.sv
package lvlc_pkg;
  localparam int GAIN_W = 6;
  typedef logic [GAIN_W-1:0] gain_t;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_LIMIT  = 1'b1
  } mode_t;

  typedef struct packed {
    logic vld;
    logic hi;
    logic clip;
  } peak_t;
endpackage

// File: rtl/lvlc_peak.sv
module lvlc_peak
  import lvlc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [3:0]          target_lvl,
  output peak_t               pk
);
  localparam int THR_SH = SAMPLE_W - 5;
  localparam logic [SAMPLE_W-1:0] CLIP_THR = SAMPLE_W'(7) << (SAMPLE_W - 4);

  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] thr;

  always_comb begin
    mag = smp_data[SAMPLE_W-1] ? (~smp_data + SAMPLE_W'(1)) : smp_data;
    thr = SAMPLE_W'({1'b0, target_lvl} + 5'd1) << THR_SH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pk <= '0;
    end else begin
      pk.vld  <= smp_valid;
      pk.hi   <= smp_valid && (mag > thr);
      pk.clip <= smp_valid && (mag > CLIP_THR);
    end
  end

  // R5
  clip_only_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    pk.clip |-> pk.vld);
endmodule

// File: rtl/lvlc_period.sv
module lvlc_period
  import lvlc_pkg::*;
#(
  parameter int NORM_BASE = 5,
  parameter int LIM_BASE  = 1,
  parameter int DCY_BASE  = 20,
  parameter int HOLD_BASE = 128,
  parameter int CNT_W     = 24
) (
  input  mode_t            mode,
  input  logic             clip,
  input  logic [3:0]       atk_code,
  input  logic [3:0]       dcy_code,
  input  logic [3:0]       hold_code,
  output logic [CNT_W-1:0] atk_per,
  output logic [CNT_W-1:0] dcy_per,
  output logic [CNT_W-1:0] hold_per
);
  localparam logic [CNT_W-1:0] NB = CNT_W'(NORM_BASE);
  localparam logic [CNT_W-1:0] LB = CNT_W'(LIM_BASE);
  localparam logic [CNT_W-1:0] DB = CNT_W'(DCY_BASE);
  localparam logic [CNT_W-1:0] HB = CNT_W'(HOLD_BASE);
  localparam logic [3:0] HOLD_TOP = 4'd10;

  logic [CNT_W-1:0] base;
  logic [3:0]       hc;

  always_comb begin
    base     = (mode == MODE_LIMIT) ? LB : NB;
    atk_per  = clip ? base : (base << atk_code);
    dcy_per  = DB << dcy_code;
    hc       = (hold_code > HOLD_TOP) ? HOLD_TOP : hold_code;
    hold_per = (hc == 4'd0) ? '0 : (HB << (hc - 4'd1));
  end
endmodule

// File: rtl/lvlc_gain.sv
module lvlc_gain
  import lvlc_pkg::*;
#(
  parameter int    CNT_W      = 24,
  parameter gain_t RESET_GAIN = 6'd16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  mode_t            mode,
  input  peak_t            pk,
  input  logic [CNT_W-1:0] atk_per,
  input  logic [CNT_W-1:0] dcy_per,
  input  logic [CNT_W-1:0] hold_per,
  input  gain_t            gain_min,
  input  gain_t            gain_max,
  input  logic             host_we,
  input  gain_t            host_gain,
  output gain_t            gain_code,
  output gain_t            gain_rb
);
  logic             run_q;
  gain_t            gain_q, gain_rb_q, start_q, gain_nxt, ceil;
  logic [CNT_W-1:0] a_cnt, q_cnt, d_cnt;
  logic running, arm, snap_hi, snap_lo, step_ok;
  logic attack, quiet, in_hold, atk_fire, dcy_fire;

  always_comb begin
    running  = run_en && run_q;
    arm      = run_en && !run_q;
    snap_hi  = gain_q > gain_max;
    snap_lo  = gain_q < gain_min;
    step_ok  = running && !snap_hi && !snap_lo;
    attack   = pk.vld && (pk.hi || pk.clip);
    quiet    = pk.vld && !attack;
    in_hold  = q_cnt < hold_per;
    atk_fire = attack && ((a_cnt + CNT_W'(1)) >= atk_per);
    dcy_fire = quiet && !in_hold && ((d_cnt + CNT_W'(1)) >= dcy_per);
    ceil     = (mode == MODE_LIMIT && start_q < gain_max) ? start_q : gain_max;

    gain_nxt = gain_q;
    if (!run_en) begin
      if (host_we) gain_nxt = host_gain;
    end else if (running) begin
      if (snap_hi)                              gain_nxt = gain_max;
      else if (snap_lo)                         gain_nxt = gain_min;
      else if (atk_fire && gain_q > gain_min)   gain_nxt = gain_q - 6'd1;
      else if (dcy_fire && gain_q < ceil)       gain_nxt = gain_q + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      gain_q    <= RESET_GAIN;
      gain_rb_q <= RESET_GAIN;
      start_q   <= RESET_GAIN;
      a_cnt     <= '0;
      q_cnt     <= '0;
      d_cnt     <= '0;
    end else begin
      run_q     <= run_en;
      gain_q    <= gain_nxt;
      gain_rb_q <= gain_nxt;
      if (!run_en) begin
        a_cnt <= '0;
        q_cnt <= '0;
        d_cnt <= '0;
      end else if (arm) begin
        start_q <= gain_q;
        a_cnt   <= '0;
        q_cnt   <= '0;
        d_cnt   <= '0;
      end else if (step_ok) begin
        if (attack) begin
          q_cnt <= '0;
          d_cnt <= '0;
          a_cnt <= atk_fire ? '0 : a_cnt + CNT_W'(1);
        end else if (quiet) begin
          a_cnt <= '0;
          if (in_hold) begin
            q_cnt <= q_cnt + CNT_W'(1);
            d_cnt <= '0;
          end else begin
            d_cnt <= dcy_fire ? '0 : d_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign gain_code = gain_q;
  assign gain_rb   = gain_rb_q;

  // R9
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && $stable(gain_min) && $stable(gain_max) && gain_min <= gain_max)
    |-> (gain_q >= gain_min && gain_q <= gain_max));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !host_we) |=> $stable(gain_q));

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (running && gain_q >= gain_min && gain_q <= gain_max)
    |=> ({1'b0, gain_q} == {1'b0, $past(gain_q)}
         || {1'b0, gain_q} == {1'b0, $past(gain_q)} + 7'd1
         || {1'b0, gain_q} + 7'd1 == {1'b0, $past(gain_q)}));

  // R8
  lim_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (running && mode == MODE_LIMIT && gain_q <= start_q && gain_q >= gain_min && gain_q <= gain_max)
    |=> (gain_q <= $past(start_q)));

  // R10
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    gain_rb_q == gain_q);
endmodule

// File: rtl/level_ctrl.sv
module level_ctrl
  import lvlc_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int NORM_BASE  = 5,
  parameter int LIM_BASE   = 1,
  parameter int DCY_BASE   = 20,
  parameter int HOLD_BASE  = 128,
  parameter int RESET_GAIN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                run_en,
  input  logic                limit_mode,
  input  logic [3:0]          target_lvl,
  input  logic [3:0]          atk_code,
  input  logic [3:0]          dcy_code,
  input  logic [3:0]          hold_code,
  input  logic [5:0]          gain_min,
  input  logic [5:0]          gain_max,
  input  logic                host_we,
  input  logic [5:0]          host_gain,
  output logic [5:0]          gain_code,
  output logic [5:0]          gain_rb
);
  localparam int MAX_AB = (NORM_BASE > LIM_BASE) ? NORM_BASE : LIM_BASE;
  localparam int MAX_DH = (DCY_BASE > HOLD_BASE) ? DCY_BASE : HOLD_BASE;
  localparam int MAX_B  = (MAX_AB > MAX_DH) ? MAX_AB : MAX_DH;
  localparam int CNT_W  = $clog2(MAX_B + 1) + 16;

  mode_t            mode;
  peak_t            pk;
  logic [CNT_W-1:0] atk_per, dcy_per, hold_per;

  assign mode = limit_mode ? MODE_LIMIT : MODE_NORMAL;

  lvlc_peak #(.SAMPLE_W(SAMPLE_W)) u_peak (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .target_lvl(target_lvl), .pk(pk)
  );

  lvlc_period #(
    .NORM_BASE(NORM_BASE), .LIM_BASE(LIM_BASE), .DCY_BASE(DCY_BASE),
    .HOLD_BASE(HOLD_BASE), .CNT_W(CNT_W)
  ) u_period (
    .mode(mode), .clip(pk.clip), .atk_code(atk_code), .dcy_code(dcy_code),
    .hold_code(hold_code), .atk_per(atk_per), .dcy_per(dcy_per), .hold_per(hold_per)
  );

  lvlc_gain #(.CNT_W(CNT_W), .RESET_GAIN(gain_t'(RESET_GAIN))) u_gain (
    .clk(clk), .rst(rst), .run_en(run_en), .mode(mode), .pk(pk),
    .atk_per(atk_per), .dcy_per(dcy_per), .hold_per(hold_per),
    .gain_min(gain_min), .gain_max(gain_max), .host_we(host_we), .host_gain(host_gain),
    .gain_code(gain_code), .gain_rb(gain_rb)
  );
endmodule

// File: tb/level_ctrl_test.sv
module level_ctrl_test;
  localparam int W = 16;
  localparam int NB = 4, LB = 1, DB = 2, HB = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic run_en = 1'b0, limit_mode = 1'b0, host_we = 1'b0;
  logic [3:0] target_lvl = 4'd7, atk_code = 4'd0, dcy_code = 4'd0, hold_code = 4'd0;
  logic [5:0] gain_min = 6'd0, gain_max = 6'd63, host_gain = 6'd0;
  logic [5:0] gain_code, gain_rb;

  int checks = 0, failures = 0;
  // bench model state
  int m_gain, m_start, m_a, m_q, m_d;

  level_ctrl #(.SAMPLE_W(W), .NORM_BASE(NB), .LIM_BASE(LB), .DCY_BASE(DB),
               .HOLD_BASE(HB), .RESET_GAIN(16)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .run_en(run_en),
    .limit_mode(limit_mode), .target_lvl(target_lvl), .atk_code(atk_code),
    .dcy_code(dcy_code), .hold_code(hold_code), .gain_min(gain_min), .gain_max(gain_max),
    .host_we(host_we), .host_gain(host_gain), .gain_code(gain_code), .gain_rb(gain_rb)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_ceil();
    if (limit_mode && m_start < int'(gain_max)) return m_start;
    return int'(gain_max);
  endfunction

  function automatic int hold_len(input int c);
    int hc = (c > 10) ? 10 : c;
    return (hc == 0) ? 0 : (HB << (hc - 1));
  endfunction

  task automatic m_snap();
    if (m_gain > int'(gain_max)) m_gain = gain_max;
    else if (m_gain < int'(gain_min)) m_gain = gain_min;
  endtask

  task automatic m_step(input int v);
    int mag = (v < 0) ? -v : v;
    int thr = (int'(target_lvl) + 1) << (W - 5);
    bit clip = mag > (7 << (W - 4));
    bit att = (mag > thr) || clip;
    int base = limit_mode ? LB : NB;
    int per = clip ? base : (base << atk_code);
    if (att) begin
      m_q = 0; m_d = 0;
      if (m_a + 1 >= per) begin
        m_a = 0;
        if (m_gain > int'(gain_min)) m_gain--;
      end else m_a++;
    end else begin
      m_a = 0;
      if (m_q < hold_len(hold_code)) begin m_q++; m_d = 0; end
      else if (m_d + 1 >= (DB << dcy_code)) begin
        m_d = 0;
        if (m_gain < m_ceil()) m_gain++;
      end else m_d++;
    end
  endtask

  // drive one sample, return after gain has had time to update (R11 latency)
  task automatic send(input int v);
    @(negedge clk); smp_valid = 1'b1; smp_data = W'(v);
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic host_load(input int g);
    @(negedge clk); host_we = 1'b1; host_gain = 6'(g);
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic enable();
    @(negedge clk); run_en = 1'b1;
    settle();
    m_start = m_gain; m_a = 0; m_q = 0; m_d = 0;
    m_snap();
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset gain_code", gain_code, 16);
    chk("R1 reset gain_rb", gain_rb, 16);

    host_load(40);
    chk("R2 host load while disabled", gain_code, 40);
    send(30000); send(-20000);
    chk("R3 samples ignored while disabled", gain_code, 40);

    // normal mode attack: code 1 -> period 8
    atk_code = 4'd1; target_lvl = 4'd7; hold_code = 4'd2; dcy_code = 4'd0;
    m_gain = 40;
    enable();
    for (int i = 0; i < 7; i++) send(20000);
    chk("R4 no step before attack period", gain_code, 40);
    @(negedge clk); smp_valid = 1'b1; smp_data = W'(-20000);
    @(negedge clk); smp_valid = 1'b0;
    chk("R11 gain unchanged one edge after strobe", gain_code, 40);
    @(negedge clk);
    chk("R11 gain stepped two edges after strobe", gain_code, 39);
    chk("R4 attack step", gain_code, 39);
    chk("R10 readback mirrors", gain_rb, 39);

    host_load(10);
    settle();
    chk("R2 host load ignored while running", gain_code, 39);

    // clip guard overrides slow attack code 3 (period 32 -> 4)
    atk_code = 4'd3;
    for (int i = 0; i < 3; i++) send(30000);
    chk("R5 clip before base period", gain_code, 39);
    send(-32768);
    chk("R5 clip at base period incl most negative", gain_code, 38);

    // hold 4 samples, decay every 2
    for (int i = 0; i < 5; i++) send(100);
    chk("R6 hold then first decay count", gain_code, 38);
    send(-100);
    chk("R7 decay step", gain_code, 39);

    // hold code clamp: 15 acts as 10 -> 1024 samples
    hold_code = 4'd15;
    send(20000);
    for (int i = 0; i < 1025; i++) send(50);
    chk("R6 hold clamp still holding", gain_code, 39);
    send(50);
    chk("R6 hold clamp then decay", gain_code, 40);

    // window snap
    @(negedge clk); gain_max = 6'd30; settle();
    chk("R9 snap down to max", gain_code, 30);
    @(negedge clk); gain_min = 6'd50; gain_max = 6'd63; settle();
    chk("R9 snap up to min", gain_code, 50);
    @(negedge clk); gain_min = 6'd0; settle();

    // limiter mode
    @(negedge clk); run_en = 1'b0;
    host_load(20);
    limit_mode = 1'b1; atk_code = 4'd0; hold_code = 4'd0; dcy_code = 4'd0;
    m_gain = 20;
    enable();
    for (int i = 0; i < 6; i++) send(10);
    chk("R8 limiter never rises above start", gain_code, 20);
    send(20000);
    chk("R4 limiter base attack", gain_code, 19);
    send(-20000);
    chk("R4 limiter second step", gain_code, 18);
    for (int i = 0; i < 4; i++) send(10);
    chk("R7 limiter decay back", gain_code, 20);
    for (int i = 0; i < 4; i++) send(10);
    chk("R8 limiter capped at start", gain_code, 20);

    // random phase against bench model
    m_gain = gain_code; m_a = 0; m_q = 0; m_d = 0;
    for (int it = 0; it < 700; it++) begin
      int r = $urandom % 40;
      if (r == 0) begin
        @(negedge clk);
        atk_code = 4'($urandom % 3); dcy_code = 4'($urandom % 3);
        hold_code = 4'($urandom % 4); target_lvl = 4'($urandom % 16);
      end else if (r == 1) begin
        int lo = $urandom % 40;
        @(negedge clk);
        gain_min = 6'(lo); gain_max = 6'(lo + ($urandom % (64 - lo)));
        settle();
        m_snap();
        chk("R9 random window", gain_code, m_gain);
      end else if (r == 2) begin
        @(negedge clk); run_en = 1'b0; limit_mode = $urandom % 2;
        @(negedge clk);
        enable();
        chk("R8 random re-enable", gain_code, m_gain);
      end else begin
        int cls = $urandom % 4;
        int mag = (cls < 2) ? ($urandom % 2048) :
                  (cls == 2) ? ($urandom % 32768) : (28673 + ($urandom % 4095));
        int v = ($urandom % 2) ? -mag : mag;
        send(v);
        m_step(v);
        chk("R4/R7 random sample", gain_code, m_gain);
        chk("R10 random readback", gain_rb, m_gain);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule